// File: doc/BRIEF.md
# Ring Oscillator Frequency Meter

This block measures how fast a slow, free-running oscillator runs by counting reference-clock cycles across a window. The window is not a fixed stretch of reference time. Software programs a number of oscillator cycles, and the window lasts exactly that many oscillator cycles. The number of reference cycles seen during the window is therefore inversely proportional to the oscillator frequency. A calibration routine typically programs 1024 oscillator cycles. It reads the count once the valid flag is up and derives a slew-rate setting from it.

Both the oscillator and the reference are presented as single-cycle tick pulses in one system clock domain. Software drives the block through a small word-addressed register port with combinational reads. A control register holds the meter enable and the window length. A read-only register holds the reference count. A monitor register holds the free-run enable, which gates the oscillator path, and the valid flag. A measurement makes progress only while the meter enable and the free-run enable are both set.

Top module: `rofm_top`

## Requirements
- R1: The control register sits at word address 0 and stores whole 32-bit writes. Bit 24 is the meter enable and bits 23:0 are the window length in oscillator cycles. A read returns the last word written, and the reset value is 0.
- R2: The monitor register sits at word address 2. Bit 8 is a writable free-run enable and bit 0 is the read-only valid flag. All its other bits read 0, writes never change valid, and word address 3 reads 0. The result register is at word address 1.
- R3: A control write that takes the meter enable from 0 to 1 clears the window count, the result and valid in that same edge, and a new measurement starts.
- R4: A measurement is active on a cycle when it is running and both enables are set. On an active cycle a reference tick adds one to the result and an oscillator tick advances the window. The cycle that carries the window-closing oscillator tick still counts its reference tick. Valid reads 1 from the next cycle on.
- R5: While the free-run enable is 0, oscillator and reference ticks are ignored: neither the window nor the result advances, and the measurement resumes when the bit is set again.
- R6: Valid stays 1 until a control write clears the meter enable, and it reads 0 in the cycle after that write.
- R7: Clearing the meter enable before the window closes aborts the measurement. Valid stays 0, the result keeps its partial count, and later ticks do not change it.
- R8: The result saturates at 2^RES_W-1 instead of wrapping.
- R9: A measurement started with a window length of 0 reads result 0 with valid 1 in the cycle after the starting write.
- R10: Once valid is set, further ticks leave the result unchanged.
- R11: A control write while the meter enable is already 1 changes the window length without restarting. The window closes on the first oscillator tick at which the window count reaches the new length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Word address of the write |
| wr_data | input | 32 | Write data, full word |
| rd_addr | input | 2 | Word address of the read |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| osc_tick | input | 1 | One pulse per cycle of the measured oscillator |
| ref_tick | input | 1 | One pulse per cycle of the reference |

## Verification
A corrupted window counter shows up as a wrong result count. It also makes valid rise on the wrong oscillator tick, and the cycle-by-cycle comparison catches that on the very next clock. A stuck or wrongly cleared run state shows up as a result that keeps moving after valid, or one that stops early. Either way the result read diverges within one cycle of the bad tick. Saturation, the zero-length window and a mid-window abort each leave a distinct fixed count, and directed reads confirm it.

// File: rtl/rofm_pkg.sv
package rofm_pkg;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 2;
  localparam int CNT_W     = 24;
  localparam int EN_BIT    = CNT_W;
  localparam int FRUN_BIT  = 8;
  localparam int VALID_BIT = 0;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL   = 2'd0,
    REG_RESULT = 2'd1,
    REG_MON    = 2'd2,
    REG_SPARE  = 2'd3
  } reg_sel_e;

  typedef logic [CNT_W-1:0] cnt_t;

  // window closes once the oscillator count reaches the programmed length
  function automatic logic window_closes(input cnt_t ticks_after, input cnt_t lim);
    return ticks_after >= lim;
  endfunction

  function automatic logic is_rise(input logic old_v, input logic new_v);
    return new_v & ~old_v;
  endfunction
endpackage

// File: rtl/rofm_regs.sv
module rofm_regs
  import rofm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              valid,
  input  logic [DATA_W-1:0] res_value,
  output logic [DATA_W-1:0] rd_data,
  output logic              ctrl_en,
  output cnt_t              ctrl_lim,
  output logic              frun_en,
  output logic              start_evt,
  output logic              stop_evt,
  output cnt_t              start_lim
);
  logic [DATA_W-1:0] ctrl_q;
  logic              frun_q;
  logic              ctrl_wr;
  logic              mon_wr;

  assign ctrl_wr   = wr_en && (wr_addr == REG_CTRL);
  assign mon_wr    = wr_en && (wr_addr == REG_MON);
  assign start_evt = ctrl_wr && is_rise(ctrl_q[EN_BIT], wr_data[EN_BIT]);
  assign stop_evt  = ctrl_wr && !wr_data[EN_BIT];
  assign start_lim = wr_data[CNT_W-1:0];

  assign ctrl_en  = ctrl_q[EN_BIT];
  assign ctrl_lim = ctrl_q[CNT_W-1:0];
  assign frun_en  = frun_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      frun_q <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl_q <= wr_data;
      if (mon_wr)  frun_q <= wr_data[FRUN_BIT];
    end
  end

  always_comb begin
    rd_data = '0;
    case (reg_sel_e'(rd_addr))
      REG_CTRL:   rd_data = ctrl_q;
      REG_RESULT: rd_data = res_value;
      REG_MON: begin
        rd_data[FRUN_BIT]  = frun_q;
        rd_data[VALID_BIT] = valid;
      end
      default:    rd_data = '0;
    endcase
  end
endmodule

// File: rtl/rofm_window.sv
module rofm_window
  import rofm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_evt,
  input  cnt_t start_lim,
  input  logic stop_evt,
  input  logic ctrl_en,
  input  logic frun_en,
  input  cnt_t ctrl_lim,
  input  logic osc_tick,
  output logic running,
  output logic valid,
  output logic active,
  output logic close_evt
);
  cnt_t wcnt;
  cnt_t ticks_next;
  logic osc_step;

  assign active     = running & ctrl_en & frun_en;
  assign osc_step   = active & osc_tick;
  assign ticks_next = wcnt + 1'b1;
  assign close_evt  = osc_step & window_closes(ticks_next, ctrl_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt    <= '0;
      running <= 1'b0;
      valid   <= 1'b0;
    end else if (start_evt) begin
      wcnt    <= '0;
      running <= (start_lim != '0);
      valid   <= (start_lim == '0);
    end else if (stop_evt) begin
      running <= 1'b0;
      valid   <= 1'b0;
    end else begin
      if (osc_step) wcnt <= ticks_next;
      if (close_evt) begin
        running <= 1'b0;
        valid   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rofm_refcnt.sv
module rofm_refcnt #(
  parameter int RES_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             count_en,
  output logic [RES_W-1:0] value
);
  function automatic logic [RES_W-1:0] sat_inc(input logic [RES_W-1:0] v);
    return (&v) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        value <= '0;
    else if (clear)    value <= '0;
    else if (count_en) value <= sat_inc(value);
  end
endmodule

// File: rtl/rofm_top.sv
module rofm_top
  import rofm_pkg::*;
#(
  parameter int RES_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              osc_tick,
  input  logic              ref_tick
);
  logic              ctrl_en;
  cnt_t              ctrl_lim;
  logic              frun_en;
  logic              start_evt;
  logic              stop_evt;
  cnt_t              start_lim;
  logic              running;
  logic              valid;
  logic              active;
  logic              close_evt;
  logic              ref_step;
  logic [RES_W-1:0]  res_cnt;
  logic [DATA_W-1:0] res_ext;

  // an aborting write wins over a reference tick in the same cycle
  assign ref_step = active & ref_tick & ~stop_evt;

  always_comb begin
    res_ext = '0;
    res_ext[RES_W-1:0] = res_cnt;
  end

  rofm_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .valid     (valid),
    .res_value (res_ext),
    .rd_data   (rd_data),
    .ctrl_en   (ctrl_en),
    .ctrl_lim  (ctrl_lim),
    .frun_en   (frun_en),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .start_lim (start_lim)
  );

  rofm_window u_window (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_evt (start_evt),
    .start_lim (start_lim),
    .stop_evt  (stop_evt),
    .ctrl_en   (ctrl_en),
    .frun_en   (frun_en),
    .ctrl_lim  (ctrl_lim),
    .osc_tick  (osc_tick),
    .running   (running),
    .valid     (valid),
    .active    (active),
    .close_evt (close_evt)
  );

  rofm_refcnt #(.RES_W(RES_W)) u_refcnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (start_evt),
    .count_en (ref_step),
    .value    (res_cnt)
  );
endmodule

// File: rtl/rofm_chk.sv
module rofm_chk #(
  parameter int RES_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_evt,
  input logic             stop_evt,
  input logic             running,
  input logic             valid,
  input logic             ctrl_en,
  input logic             frun_en,
  input logic             close_evt,
  input logic [RES_W-1:0] res_cnt
);
  // R3
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (res_cnt == '0));

  // R3
  run_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> ctrl_en);

  // R4
  close_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (close_evt && !start_evt && !stop_evt) |=> (valid && !running));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!frun_en && !start_evt) |=> $stable(res_cnt));

  // R6
  stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (!valid && !running));

  // R8
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((&res_cnt) && !start_evt) |=> (&res_cnt));

  // R10
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !start_evt) |=> $stable(res_cnt));
endmodule

bind rofm_top rofm_chk #(.RES_W(RES_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_evt (start_evt),
  .stop_evt  (stop_evt),
  .running   (running),
  .valid     (valid),
  .ctrl_en   (ctrl_en),
  .frun_en   (frun_en),
  .close_evt (close_evt),
  .res_cnt   (res_cnt)
);

// File: tb/rofm_top_tb.sv
module rofm_top_tb;
  localparam int TB_RES_W = 8;
  localparam int RES_MAX  = (1 << TB_RES_W) - 1;
  localparam logic [31:0] EN = 32'h0100_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        osc_tick = 1'b0;
  logic        ref_tick = 1'b0;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  rofm_top #(.RES_W(TB_RES_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .osc_tick(osc_tick), .ref_tick(ref_tick)
  );

  // behavioural reference model
  logic [31:0] m_ctrl;
  bit          m_frun, m_valid, m_run;
  int          m_win, m_res;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_frun = 0; m_valid = 0; m_run = 0; m_win = 0; m_res = 0;
    end else begin
      bit to_ctrl, act;
      to_ctrl = wr_en && (wr_addr == 2'd0);
      act = m_run && m_ctrl[24] && m_frun;
      if (to_ctrl && wr_data[24] && !m_ctrl[24]) begin
        m_win = 0; m_res = 0;
        m_run = (wr_data[23:0] != 0);
        m_valid = (wr_data[23:0] == 0);
      end else if (to_ctrl && !wr_data[24]) begin
        m_run = 0; m_valid = 0;
      end else if (act) begin
        if (ref_tick && m_res < RES_MAX) m_res++;
        if (osc_tick) begin
          m_win++;
          if (m_win >= int'(m_ctrl[23:0])) begin m_run = 0; m_valid = 1; end
        end
      end
      if (to_ctrl) m_ctrl = wr_data;
      if (wr_en && wr_addr == 2'd2) m_frun = wr_data[8];
    end
  end

  function automatic logic [31:0] model_read(input logic [1:0] a);
    case (a)
      2'd0: return m_ctrl;
      2'd1: return 32'(m_res);
      2'd2: return {23'd0, m_frun, 7'd0, m_valid};
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  // per-cycle comparison, well after the edge
  always @(posedge clk) begin
    #3;
    if (rst_n && !finished) begin
      case (rd_addr)
        2'd0: chk("R1 cycle", rd_data, model_read(rd_addr));
        2'd1: chk("R4 cycle", rd_data, model_read(rd_addr));
        default: chk("R2 cycle", rd_data, model_read(rd_addr));
      endcase
    end
  end

  task automatic drive(input bit we, input logic [1:0] a, input logic [31:0] d,
                       input bit o, input bit r);
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; osc_tick = o; ref_tick = r;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    drive(1'b1, a, d, 1'b0, 1'b0);
  endtask

  task automatic peek(input logic [1:0] a, output logic [31:0] v);
    drive(1'b0, 2'd0, 32'd0, 1'b0, 1'b0);
    rd_addr = a;
    #1 v = rd_data;
  endtask

  task automatic ticks(input int n, input int p_osc, input int p_ref);
    for (int k = 0; k < n; k++)
      drive(1'b0, 2'd0, 32'd0, (k % p_osc) == p_osc - 1, (k % p_ref) == 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    peek(2'd0, v); chk("R1 reset ctrl", v, 32'h0);
    peek(2'd1, v); chk("R2 reset result", v, 32'h0);
    peek(2'd2, v); chk("R2 reset monitor", v, 32'h0);

    // R1 full-word write and readback, enable bit clear
    wr(2'd0, 32'h5A00_0003);
    peek(2'd0, v); chk("R1 readback", v, 32'h5A00_0003);
    // R2 monitor bits: only free-run is writable
    wr(2'd2, 32'hFFFF_FFFF);
    peek(2'd2, v); chk("R2 monitor write", v, 32'h0000_0100);
    peek(2'd3, v); chk("R2 spare address", v, 32'h0);

    // R4 window of 8 oscillator cycles, oscillator every 3rd cycle
    wr(2'd0, EN | 32'd8);
    ticks(24, 3, 1);
    peek(2'd1, v); chk("R4 count 8x3", v, 32'd24);
    peek(2'd2, v); chk("R4 valid set", v, 32'h101);
    // R10 ticks after completion do not move the result
    ticks(6, 1, 1);
    peek(2'd1, v); chk("R10 result held", v, 32'd24);
    // R6 valid persists, then clears on enable write
    peek(2'd2, v); chk("R6 valid held", v, 32'h101);
    wr(2'd0, 32'h0);
    peek(2'd2, v); chk("R6 valid cleared", v, 32'h100);

    // R4 second pattern: oscillator every 4th, reference every 2nd
    wr(2'd0, EN | 32'd5);
    ticks(20, 4, 2);
    peek(2'd1, v); chk("R4 count 5x4 half ref", v, 32'd10);
    wr(2'd0, 32'h0);

    // R5 ticks ignored while free-run is clear
    wr(2'd2, 32'h0);
    wr(2'd0, EN | 32'd4);
    ticks(10, 1, 1);
    peek(2'd1, v); chk("R5 no count when gated", v, 32'd0);
    peek(2'd2, v); chk("R5 no valid when gated", v, 32'h0);
    wr(2'd2, 32'h100);
    ticks(3, 1, 1);
    peek(2'd2, v); chk("R5 window resumed not done", v, 32'h100);
    ticks(1, 1, 1);
    peek(2'd1, v); chk("R5 resumed count", v, 32'd4);
    peek(2'd2, v); chk("R4 valid after resume", v, 32'h101);
    wr(2'd0, 32'h0);

    // R7 abort mid-window
    wr(2'd0, EN | 32'd10);
    ticks(3, 1, 1);
    wr(2'd0, 32'h0);
    peek(2'd2, v); chk("R7 no valid on abort", v, 32'h100);
    ticks(5, 1, 1);
    peek(2'd1, v); chk("R7 partial count kept", v, 32'd3);

    // R3 new rising edge clears result
    wr(2'd0, EN | 32'd2);
    peek(2'd1, v); chk("R3 result cleared", v, 32'd0);
    peek(2'd2, v); chk("R3 valid cleared", v, 32'h100);

    // R11 limit change while enabled, no restart
    ticks(1, 1, 1);
    wr(2'd0, EN | 32'd6);
    ticks(4, 1, 1);
    peek(2'd2, v); chk("R11 still running", v, 32'h100);
    ticks(1, 1, 1);
    peek(2'd1, v); chk("R11 count to new limit", v, 32'd6);
    peek(2'd2, v); chk("R11 valid", v, 32'h101);
    wr(2'd0, 32'h0);

    // R9 zero-length window
    wr(2'd0, EN);
    peek(2'd2, v); chk("R9 valid at once", v, 32'h101);
    peek(2'd1, v); chk("R9 zero result", v, 32'd0);
    ticks(5, 1, 1);
    peek(2'd1, v); chk("R9 result stays zero", v, 32'd0);
    wr(2'd0, 32'h0);

    // R8 1024-cycle window saturates the narrow result
    wr(2'd0, EN | 32'd1024);
    ticks(1024, 1, 1);
    peek(2'd1, v); chk("R8 saturated", v, 32'(RES_MAX));
    peek(2'd2, v); chk("R8 valid after saturation", v, 32'h101);

    repeat (2) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule